// File: doc/BRIEF.md
# Floppy Data-Rate Select Control Register

This block is the write-only rate and mode register of a floppy disk controller. One byte write sets the data-rate code, the write-precompensation code, a manual low-power request and a software-reset request. A second register elsewhere in the controller, the configuration control register, can also write the data-rate code. The active rate is whichever of the two was written last.

The block drives the active rate code, the precompensation code, a low-power flag with matching clock-gate and data-separator enables, and a one-cycle soft-reset pulse. It also takes strobes for data-register and main-status-register accesses, because either access ends low-power mode. A readable shadow byte mirrors the register for software. Every output is registered, so each effect appears on the clock edge that samples the write or strobe.

Top module: `fdc_rate_select_reg`

## Requirements
- R1: After a synchronous reset, the shadow reads 0x02, rate is 2'b10 (250 Kbps), pcomp is 3'b000, low_power and soft_rst are 0, and clk_gate_en and sep_en are 1.
- R2: A write (wr_en) stores wr_data[1:0] as the rate code and wr_data[4:2] as the precompensation code. Shadow bit 5 always reads 0, whatever was written.
- R3: A ccr_wr_en strobe loads ccr_rate into the active rate code and leaves the precompensation and low-power state unchanged.
- R4: If wr_en and ccr_wr_en are asserted in the same cycle, the rate code comes from wr_data[1:0].
- R5: In a cycle with no write, no strobe and no reset, rate and pcomp hold their values.
- R6: A write with wr_data[6]=1 and wr_data[7]=0 sets low_power. While low_power is set, clk_gate_en and sep_en are 0.
- R7: A write with wr_data[6]=0 does not end low-power mode.
- R8: A data_acc or stat_acc strobe clears low_power on the next edge. It also overrides a low-power request written in the same cycle.
- R9: A write with wr_data[7]=1 raises soft_rst for exactly the following cycle and clears low_power. Shadow bit 7 reads 0. The rate and precompensation fields of that write are stored as usual.
- R10: The shadow byte reads {1'b0, low_power, 1'b0, pcomp, rate}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for this register |
| wr_data | input | 8 | Write data byte |
| ccr_wr_en | input | 1 | Configuration control register rate write strobe |
| ccr_rate | input | 2 | Rate code written through the configuration register |
| data_acc | input | 1 | Data register access strobe |
| stat_acc | input | 1 | Main status register access strobe |
| shadow | output | 8 | Readable mirror of the register |
| rate | output | 2 | Active data-rate code |
| pcomp | output | 3 | Precompensation code |
| low_power | output | 1 | Manual low-power flag |
| clk_gate_en | output | 1 | Controller clock enable, low while in low power |
| sep_en | output | 1 | Data-separator enable, low while in low power |
| soft_rst | output | 1 | One-cycle software-reset pulse |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a register write and a configuration rate write on the same edge. The other is a low-power request written in the same cycle as a data access. Both need two independent strobes aligned on one edge after the block has been moved into a known non-default state. The vector table drives the strobes together in single rows, after preceding rows have set distinct rate and low-power values. A wrong winner then changes the shadow byte.

// File: rtl/fdc_rate_pkg.sv
package fdc_rate_pkg;
  localparam int RATE_W  = 2;
  localparam int PCOMP_W = 3;
  localparam int BYTE_W  = 8;

  // bit positions that software decodes in the byte
  localparam int RATE_LSB  = 0;
  localparam int PCOMP_LSB = 2;
  localparam int RSVD_BIT  = 5;
  localparam int LP_BIT    = 6;
  localparam int SRST_BIT  = 7;

  typedef logic [RATE_W-1:0]  rate_t;
  typedef logic [PCOMP_W-1:0] pcomp_t;
endpackage

// File: rtl/drs_rate_arb.sv
module drs_rate_arb
  import fdc_rate_pkg::*;
#(
  parameter rate_t RST_RATE = 2'b10
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  own_wr,
  input  rate_t own_rate,
  input  logic  ccr_wr,
  input  rate_t ccr_rate,
  output rate_t rate_q
);
  always_ff @(posedge clk) begin
    if (rst)         rate_q <= RST_RATE;
    else if (own_wr) rate_q <= own_rate;
    else if (ccr_wr) rate_q <= ccr_rate;
  end

  AST_CCR_LOADS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && ccr_wr && !own_wr) |-> rate_q == $past(ccr_rate)); // R3
  AST_OWN_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && own_wr) |-> rate_q == $past(own_rate)); // R4
  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !own_wr && !ccr_wr) |-> $stable(rate_q)); // R5
endmodule

// File: rtl/drs_power_ctl.sv
module drs_power_ctl (
  input  logic clk,
  input  logic rst,
  input  logic enter_req,
  input  logic exit_req,
  output logic lp_q,
  output logic clk_en_q,
  output logic sep_en_q
);
  logic lp_d;

  always_comb begin
    lp_d = lp_q;
    if (enter_req) lp_d = 1'b1;
    if (exit_req)  lp_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_q     <= 1'b0;
      clk_en_q <= 1'b1;
      sep_en_q <= 1'b1;
    end else begin
      lp_q     <= lp_d;
      clk_en_q <= !lp_d;
      sep_en_q <= !lp_d;
    end
  end

  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    exit_req |=> !lp_q); // R8
  AST_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
    lp_q |-> (!clk_en_q && !sep_en_q)); // R6
  AST_NO_SPURIOUS_EXIT: assert property (@(posedge clk) disable iff (rst)
    (lp_q && !exit_req) |=> lp_q); // R7
endmodule

// File: rtl/drs_srst_pulse.sv
module drs_srst_pulse (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse_q
);
  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= trig;
  end

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    pulse_q |-> $past(trig)); // R9
endmodule

// File: rtl/fdc_rate_select_reg.sv
module fdc_rate_select_reg
  import fdc_rate_pkg::*;
#(
  parameter logic [RATE_W-1:0]  RST_RATE  = 2'b10,
  parameter logic [PCOMP_W-1:0] RST_PCOMP = 3'b000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              ccr_wr_en,
  input  logic [RATE_W-1:0] ccr_rate,
  input  logic              data_acc,
  input  logic              stat_acc,
  output logic [BYTE_W-1:0] shadow,
  output logic [RATE_W-1:0] rate,
  output logic [PCOMP_W-1:0] pcomp,
  output logic              low_power,
  output logic              clk_gate_en,
  output logic              sep_en,
  output logic              soft_rst
);
  logic srst_req, lp_enter, lp_exit;

  assign srst_req = wr_en && wr_data[SRST_BIT];
  assign lp_enter = wr_en && wr_data[LP_BIT];
  assign lp_exit  = srst_req || data_acc || stat_acc;

  drs_rate_arb #(.RST_RATE(RST_RATE)) u_rate (
    .clk      (clk),
    .rst      (rst),
    .own_wr   (wr_en),
    .own_rate (wr_data[RATE_LSB +: RATE_W]),
    .ccr_wr   (ccr_wr_en),
    .ccr_rate (ccr_rate),
    .rate_q   (rate)
  );

  always_ff @(posedge clk) begin
    if (rst)        pcomp <= RST_PCOMP;
    else if (wr_en) pcomp <= wr_data[PCOMP_LSB +: PCOMP_W];
  end

  drs_power_ctl u_pwr (
    .clk       (clk),
    .rst       (rst),
    .enter_req (lp_enter),
    .exit_req  (lp_exit),
    .lp_q      (low_power),
    .clk_en_q  (clk_gate_en),
    .sep_en_q  (sep_en)
  );

  drs_srst_pulse u_srst (
    .clk     (clk),
    .rst     (rst),
    .trig    (srst_req),
    .pulse_q (soft_rst)
  );

  // reserved bit and self-clearing reset bit always read back as zero
  always_comb begin
    shadow                            = '0;
    shadow[RATE_LSB +: RATE_W]        = rate;
    shadow[PCOMP_LSB +: PCOMP_W]      = pcomp;
    shadow[LP_BIT]                    = low_power;
    shadow[RSVD_BIT]                  = 1'b0;
    shadow[SRST_BIT]                  = 1'b0;
  end

  AST_PCOMP_WRITE: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wr_en) |-> pcomp == $past(wr_data[PCOMP_LSB +: PCOMP_W])); // R2
  AST_PCOMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !wr_en) |-> $stable(pcomp)); // R3
  AST_SRST_EXITS_LP: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> !low_power); // R9
endmodule

// File: tb/tb_fdc_rate_select_reg.sv
module tb_fdc_rate_select_reg;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en, ccr_wr_en, data_acc, stat_acc;
  logic [7:0] wr_data;
  logic [1:0] ccr_rate;
  logic [7:0] shadow;
  logic [1:0] rate;
  logic [2:0] pcomp;
  logic       low_power, clk_gate_en, sep_en, soft_rst;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  fdc_rate_select_reg dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ccr_wr_en(ccr_wr_en), .ccr_rate(ccr_rate),
    .data_acc(data_acc), .stat_acc(stat_acc),
    .shadow(shadow), .rate(rate), .pcomp(pcomp), .low_power(low_power),
    .clk_gate_en(clk_gate_en), .sep_en(sep_en), .soft_rst(soft_rst)
  );

  // {wr, data[8], ccr_wr, ccr_rate[2], dacc, sacc, exp_shadow[8], exp_srst}
  localparam int NV = 16;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 8'h1D, 1'b0, 2'd0, 1'b0, 1'b0, 8'h1D, 1'b0}, // R2 fields
    {1'b1, 8'h3E, 1'b0, 2'd0, 1'b0, 1'b0, 8'h1E, 1'b0}, // R2 bit5 dropped
    {1'b0, 8'h00, 1'b1, 2'd3, 1'b0, 1'b0, 8'h1F, 1'b0}, // R3 ccr rate
    {1'b0, 8'hFF, 1'b0, 2'd0, 1'b0, 1'b0, 8'h1F, 1'b0}, // R5 idle
    {1'b1, 8'h40, 1'b0, 2'd0, 1'b0, 1'b0, 8'h40, 1'b0}, // R6 enter
    {1'b1, 8'h05, 1'b0, 2'd0, 1'b0, 1'b0, 8'h45, 1'b0}, // R7 stays
    {1'b0, 8'h00, 1'b0, 2'd0, 1'b1, 1'b0, 8'h05, 1'b0}, // R8 data exit
    {1'b1, 8'h41, 1'b0, 2'd0, 1'b0, 1'b0, 8'h41, 1'b0}, // R6
    {1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b1, 8'h01, 1'b0}, // R8 status exit
    {1'b1, 8'h8E, 1'b0, 2'd0, 1'b0, 1'b0, 8'h0E, 1'b1}, // R9 pulse
    {1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 8'h0E, 1'b0}, // R9 one cycle
    {1'b1, 8'h40, 1'b0, 2'd0, 1'b0, 1'b0, 8'h40, 1'b0}, // R6
    {1'b1, 8'h80, 1'b0, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1}, // R9 exits lp
    {1'b1, 8'h0C, 1'b1, 2'd1, 1'b0, 1'b0, 8'h0C, 1'b0}, // R4 collision
    {1'b0, 8'h00, 1'b1, 2'd2, 1'b0, 1'b0, 8'h0E, 1'b0}, // R3
    {1'b1, 8'h44, 1'b0, 2'd0, 1'b1, 1'b0, 8'h04, 1'b0}  // R8 exit beats entry
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_data = 0; ccr_wr_en = 0; ccr_rate = 0; data_acc = 0; stat_acc = 0;
  endtask

  task automatic check_outs(input string req, input logic [7:0] e, input logic es);
    chk(req, {24'd0, shadow}, {24'd0, e});
    chk({req, " rate"}, {30'd0, rate}, {30'd0, e[1:0]});
    chk({req, " pcomp"}, {29'd0, pcomp}, {29'd0, e[4:2]});
    chk({req, " lp"}, {31'd0, low_power}, {31'd0, e[6]});
    chk({req, " R6 gates"}, {30'd0, clk_gate_en, sep_en}, {30'd0, !e[6], !e[6]});
    chk({req, " R9 srst"}, {31'd0, soft_rst}, {31'd0, es});
  endtask

  initial begin
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    check_outs("R1 reset", 8'h02, 1'b0);

    for (int i = 0; i < NV; i++) begin
      wr_en     = VEC[i][22];
      wr_data   = VEC[i][21:14];
      ccr_wr_en = VEC[i][13];
      ccr_rate  = VEC[i][12:11];
      data_acc  = VEC[i][10];
      stat_acc  = VEC[i][9];
      @(negedge clk);
      idle();
      check_outs($sformatf("R10 vec%0d", i), VEC[i][8:1], VEC[i][0]);
    end

    // back-to-back soft resets: two pulses
    wr_en = 1; wr_data = 8'h81; @(negedge clk);
    check_outs("R9 b2b first", 8'h01, 1'b1);
    wr_data = 8'h82; @(negedge clk);
    idle();
    check_outs("R9 b2b second", 8'h02, 1'b1);
    @(negedge clk);
    check_outs("R9 b2b end", 8'h02, 1'b0);

    // reset while in low power restores defaults
    wr_en = 1; wr_data = 8'h5F; @(negedge clk);
    idle();
    check_outs("R6 pre-reset", 8'h5F, 1'b0);
    rst = 1; @(negedge clk); rst = 0;
    check_outs("R1 reset from lp", 8'h02, 1'b0);

    // strobes outside low power have no effect
    data_acc = 1; stat_acc = 1; @(negedge clk);
    idle();
    check_outs("R5 strobes idle", 8'h02, 1'b0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        errors++;
        vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule